// File: doc/BRIEF.md
# Prioritised Nested Interrupt Controller

This block sits beside a 16-bit CPU and decides which of a set of interrupt request lines the CPU should serve next. Every source has a local enable input and a programmable 3-bit level. A request competes only when it is enabled, its level is non-zero, the CPU's global mask input is clear, and its level is strictly above the level the CPU is currently working at. The winner is picked by highest level. Among sources of equal level, the one whose vector sits higher in memory wins. That is the lowest source index. The choice is held in a register and offered to the CPU through `int_req` and a 16-bit vector address.

The CPU accepts with a one-cycle `int_ack`. The controller then pushes the working level onto an internal 8-entry stack and raises the working level to that of the accepted source. A one-cycle `int_rti` pops the stack and restores the previous level, so handlers nest correctly. Requests of lower level that arrive during a handler wait. They are served in descending level order as handlers return. If the chosen source withdraws before acknowledge, a fixed spurious vector is handed out instead.

Top module: `prio_intc`

## Requirements
- R1: Each source level resets to 1. A source whose level is 0 never causes `int_req`, whatever its enable bit says.
- R2: A source is eligible only when its request and enable are high, `gmask` is low, and its level is strictly greater than `cur_lvl`. A source whose level equals `cur_lvl` is not eligible.
- R3: Among eligible sources the highest level wins. Equal levels go to the lower source index.
- R4: The vector address is the base byte followed by the low byte 0xFE − 2·index (source 0 → 0xFE, source 1 → 0xFC). The base resets to 0xFF. A base write changes `vec_addr` from the clock edge that stores it.
- R5: `int_req` is registered. It rises one edge after an eligible request is sampled. It is low in the cycle after any `int_ack` or `int_rti`.
- R6: `int_ack` while `int_req` is high and the winner is still requesting pushes `cur_lvl` and loads the winner's level. `cur_lvl` changes only on acknowledge or return. `int_ack` while `int_req` is low is ignored.
- R7: `int_rti` pops the stack into `cur_lvl`, restoring the level in force before the matching acknowledge.
- R8: If the winner's request or enable has dropped, `vec_addr` shows the spurious vector, with low byte 0xFE − 2·NSRC (0xDE for 16 sources). Acknowledging it pushes the stack and leaves `cur_lvl` unchanged. With no winner, `vec_addr` also shows this vector.
- R9: Lower-level requests held off during a handler are served in descending level order as handlers return.
- R10: The stack holds 8 levels. A ninth push, or a pop of an empty stack, sets `stk_err`, which stays set until reset.
- R11: `int_ack` and `int_rti` in the same cycle give `cur_lvl` the new winner's level and leave the stack depth and contents unchanged.
- R12: A level write is stored on the next edge. From that edge arbitration uses the new level, so `int_req` reflects it one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | NSRC | Request line per source |
| irq_en | input | NSRC | Local enable per source |
| gmask | input | 1 | CPU global interrupt mask, 1 = masked |
| lvl_we | input | 1 | Level write strobe |
| lvl_idx | input | IDXW | Source index for the level write |
| lvl_din | input | 3 | Level value to write |
| base_we | input | 1 | Vector base write strobe |
| base_din | input | 8 | Vector base value |
| int_ack | input | 1 | CPU accepts the offered vector |
| int_rti | input | 1 | CPU returns from a handler |
| int_req | output | 1 | Interrupt request to the CPU |
| vec_addr | output | 16 | Vector address to fetch |
| cur_lvl | output | 3 | Current working level |
| stk_err | output | 1 | Sticky stack overflow/underflow flag |

## Verification
Acknowledge of a new, higher-level request and return from the running handler can land in the same cycle. The bench provokes this with a level-3 handler running on a stack holding 0. It raises a level-5 source, then pulses `int_ack` and `int_rti` together. The result is judged at the ports: `cur_lvl` must read 5 at once, a single later return must bring it back to 0, and `stk_err` must stay clear. Together these show the depth and the saved entry were both left intact.

// File: rtl/intc_pkg.sv
// Shared types and vector arithmetic for the nested interrupt controller.
// Assumes vectors are 2 bytes wide and placed downward from offset 0xFE.
package intc_pkg;
    localparam int LVL_W = 3;
    typedef logic [LVL_W-1:0] lvl_t;
    localparam logic [7:0] VEC_TOP = 8'hFE;

    // Low vector byte for a given source index (index NSRC = spurious slot).
    function automatic logic [7:0] vec_lo(input int unsigned idx);
        return VEC_TOP - 8'(2 * idx);
    endfunction
endpackage

// File: rtl/intc_cfg_regs.sv
// Per-source priority level registers and the vector base register.
// Assumes a single write port per register kind; writes land on the next edge.
module intc_cfg_regs
    import intc_pkg::*;
#(
    parameter int NSRC    = 16,
    parameter int IDXW    = $clog2(NSRC),
    parameter int RST_LVL = 1,
    parameter logic [7:0] RST_BASE = 8'hFF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  lvl_we,
    input  logic [IDXW-1:0]       lvl_idx,
    input  lvl_t                  lvl_din,
    input  logic                  base_we,
    input  logic [7:0]            base_din,
    output logic [NSRC*LVL_W-1:0] lvls,
    output logic [7:0]            base
);
    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_lvl
            // Hold the programmed level of source g.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    lvls[g*LVL_W +: LVL_W] <= lvl_t'(RST_LVL);
                else if (lvl_we && (lvl_idx == IDXW'(g)))
                    lvls[g*LVL_W +: LVL_W] <= lvl_din;
            end
        end
    endgenerate

    // Hold the vector base byte.
    always_ff @(posedge clk) begin
        if (!rst_n)       base <= RST_BASE;
        else if (base_we) base <= base_din;
    end
endmodule

// File: rtl/intc_arbiter.sv
// Picks the highest-level eligible source and registers the choice.
// Ties go to the lower index (higher vector address). A flush clears the
// registered choice so a stale winner is never offered after a level change.
module intc_arbiter
    import intc_pkg::*;
#(
    parameter int NSRC = 16,
    parameter int IDXW = $clog2(NSRC)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NSRC-1:0]       req,
    input  logic [NSRC-1:0]       en,
    input  logic [NSRC*LVL_W-1:0] lvls,
    input  logic                  gmask,
    input  lvl_t                  cur_lvl,
    input  logic                  flush,
    output logic                  win_valid,
    output logic [IDXW-1:0]       win_idx,
    output lvl_t                  win_lvl
);
    logic            best_v;
    logic [IDXW-1:0] best_i;
    lvl_t            best_l;

    // Scan from the highest index down so equal levels favour lower indices.
    always_comb begin
        best_v = 1'b0;
        best_i = '0;
        best_l = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req[i] && en[i] && !gmask &&
                (lvls[i*LVL_W +: LVL_W] != '0) &&
                (lvls[i*LVL_W +: LVL_W] > cur_lvl) &&
                (!best_v || (lvls[i*LVL_W +: LVL_W] >= best_l))) begin
                best_v = 1'b1;
                best_i = IDXW'(i);
                best_l = lvls[i*LVL_W +: LVL_W];
            end
        end
    end

    // Register the winner; flush on any level transition.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            win_valid <= 1'b0;
            win_idx   <= '0;
            win_lvl   <= '0;
        end else begin
            win_valid <= best_v;
            win_idx   <= best_i;
            win_lvl   <= best_l;
        end
    end
endmodule

// File: rtl/intc_lvl_stack.sv
// LIFO of saved working levels. A simultaneous push and pop leaves depth and
// contents unchanged. Overflow or underflow sets a sticky error and is dropped.
module intc_lvl_stack
    import intc_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic pop,
    input  lvl_t din,
    output lvl_t top,
    output logic err
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = $clog2(DEPTH + 1);

    lvl_t          mem [DEPTH];
    logic [PW-1:0] ptr;
    logic [PW-1:0] ptr_m1;

    assign ptr_m1 = ptr - PW'(1);
    assign top    = (ptr == '0) ? lvl_t'(0) : mem[ptr_m1[AW-1:0]];

    // Maintain pointer and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
            err <= 1'b0;
        end else if (push && pop) begin
            if (ptr == '0) err <= 1'b1;
        end else if (push) begin
            if (ptr == PW'(DEPTH)) err <= 1'b1;
            else                   ptr <= ptr + PW'(1);
        end else if (pop) begin
            if (ptr == '0) err <= 1'b1;
            else           ptr <= ptr_m1;
        end
    end

    // Store a pushed level when there is room.
    always_ff @(posedge clk) begin
        if (rst_n && push && !pop && (ptr != PW'(DEPTH)))
            mem[ptr[AW-1:0]] <= din;
    end
endmodule

// File: rtl/prio_intc.sv
// Top of the nested interrupt controller: configuration, arbitration,
// level stack and the current working level. Assumes the CPU pulses
// int_ack / int_rti for one cycle and drives gmask from its own mask bit.
module prio_intc
    import intc_pkg::*;
#(
    parameter int NSRC  = 16,
    parameter int DEPTH = 8,
    parameter int IDXW  = $clog2(NSRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_req,
    input  logic [NSRC-1:0]   irq_en,
    input  logic              gmask,
    input  logic              lvl_we,
    input  logic [IDXW-1:0]   lvl_idx,
    input  logic [2:0]        lvl_din,
    input  logic              base_we,
    input  logic [7:0]        base_din,
    input  logic              int_ack,
    input  logic              int_rti,
    output logic              int_req,
    output logic [15:0]       vec_addr,
    output logic [2:0]        cur_lvl,
    output logic              stk_err
);
    localparam logic [7:0] SPUR_LO = vec_lo(NSRC);

    logic [NSRC*LVL_W-1:0] lvls;
    logic [7:0]            base;
    logic                  win_valid;
    logic [IDXW-1:0]       win_idx;
    lvl_t                  win_lvl;
    lvl_t                  stk_top;
    logic                  live;
    logic                  take;

    intc_cfg_regs #(.NSRC(NSRC), .IDXW(IDXW)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .lvl_we(lvl_we), .lvl_idx(lvl_idx), .lvl_din(lvl_din),
        .base_we(base_we), .base_din(base_din),
        .lvls(lvls), .base(base)
    );

    intc_arbiter #(.NSRC(NSRC), .IDXW(IDXW)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .req(irq_req), .en(irq_en), .lvls(lvls), .gmask(gmask),
        .cur_lvl(cur_lvl), .flush(take || int_rti),
        .win_valid(win_valid), .win_idx(win_idx), .win_lvl(win_lvl)
    );

    intc_lvl_stack #(.DEPTH(DEPTH)) u_stk (
        .clk(clk), .rst_n(rst_n),
        .push(take), .pop(int_rti), .din(cur_lvl),
        .top(stk_top), .err(stk_err)
    );

    // Winner still present at delivery time; otherwise the spurious slot.
    assign live     = win_valid && irq_req[win_idx] && irq_en[win_idx];
    assign take     = int_ack && win_valid;
    assign int_req  = win_valid;
    assign vec_addr = {base, live ? vec_lo(32'(win_idx)) : SPUR_LO};

    // Update the working level on acknowledge and return.
    always_ff @(posedge clk) begin
        if (!rst_n)               cur_lvl <= '0;
        else if (take && live)    cur_lvl <= win_lvl;
        else if (int_rti)         cur_lvl <= stk_top;
    end
endmodule

// File: rtl/intc_checker.sv
// Port-level properties of the nested interrupt controller, bound to the top.
module intc_checker #(
    parameter int NSRC = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        gmask,
    input logic        int_ack,
    input logic        int_rti,
    input logic        int_req,
    input logic [15:0] vec_addr,
    input logic [2:0]  cur_lvl,
    input logic        stk_err
);
    localparam logic [7:0] SPUR = 8'hFE - 8'(2 * NSRC);

    assert_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> !$past(gmask));

    assert_ack_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack || int_rti) |=> !int_req);

    assert_hold_lvl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_ack && !int_rti) |=> $stable(cur_lvl));

    assert_raise_lvl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && int_req && vec_addr[7:0] != SPUR) |=> cur_lvl > $past(cur_lvl));

    assert_spur_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && int_req && !int_rti && vec_addr[7:0] == SPUR) |=> $stable(cur_lvl));

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stk_err |=> stk_err);
endmodule

bind prio_intc intc_checker #(.NSRC(NSRC)) u_chk (
    .clk(clk), .rst_n(rst_n), .gmask(gmask), .int_ack(int_ack),
    .int_rti(int_rti), .int_req(int_req), .vec_addr(vec_addr),
    .cur_lvl(cur_lvl), .stk_err(stk_err)
);

// File: tb/sim_prio_intc.sv
`timescale 1ns/1ps
// Self-checking bench: a vector table for arbitration, then directed tests.
module sim_prio_intc;
    localparam int NSRC = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] irq_req, irq_en;
    logic        gmask, lvl_we, base_we, int_ack, int_rti;
    logic [3:0]  lvl_idx;
    logic [2:0]  lvl_din;
    logic [7:0]  base_din;
    logic        int_req, stk_err;
    logic [15:0] vec_addr;
    logic [2:0]  cur_lvl;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    prio_intc #(.NSRC(NSRC), .DEPTH(8)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en),
        .gmask(gmask), .lvl_we(lvl_we), .lvl_idx(lvl_idx), .lvl_din(lvl_din),
        .base_we(base_we), .base_din(base_din), .int_ack(int_ack),
        .int_rti(int_rti), .int_req(int_req), .vec_addr(vec_addr),
        .cur_lvl(cur_lvl), .stk_err(stk_err)
    );

    // {req, en, gmask, expected int_req, expected vector low byte}
    localparam int NV = 9;
    localparam logic [41:0] VTAB [NV] = '{
        {16'h0000, 16'hFFFF, 1'b0, 1'b0, 8'hDE},  // R5 idle
        {16'h0001, 16'hFFFF, 1'b0, 1'b1, 8'hFE},  // R4 source 0
        {16'h0006, 16'hFFFF, 1'b0, 1'b1, 8'hFC},  // R3 tie at level 5
        {16'h0009, 16'hFFFF, 1'b0, 1'b1, 8'hF8},  // R3 level 7 beats 2
        {16'h0010, 16'hFFFF, 1'b0, 1'b0, 8'hDE},  // R1 level 0
        {16'h0008, 16'hFFF7, 1'b0, 1'b0, 8'hDE},  // R2 disabled
        {16'h0001, 16'hFFFF, 1'b1, 1'b0, 8'hDE},  // R2 masked
        {16'h8020, 16'hFFFF, 1'b0, 1'b1, 8'hF4},  // R3 level 3 beats 1
        {16'hC000, 16'hFFFF, 1'b0, 1'b1, 8'hE2}   // R3 tie at default level
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 0; irq_req = '0; irq_en = '1; gmask = 0; lvl_we = 0;
        lvl_idx = '0; lvl_din = '0; base_we = 0; base_din = '0;
        int_ack = 0; int_rti = 0;
        step(); step();
        rst_n = 1;
        step();
    endtask

    task automatic set_lvl(input int idx, input int lvl);
        lvl_we = 1; lvl_idx = 4'(idx); lvl_din = 3'(lvl);
        step();
        lvl_we = 0;
    endtask

    task automatic ack();
        int_ack = 1; step(); int_ack = 0;
    endtask

    task automatic rti();
        int_rti = 1; step(); int_rti = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        do_reset();
        // Reset state (R4, R5, R6, R10)
        check("R5 reset int_req", 32'(int_req), 0);
        check("R6 reset cur_lvl", 32'(cur_lvl), 0);
        check("R4 reset vector", 32'(vec_addr), 32'hFFDE);
        check("R10 reset err", 32'(stk_err), 0);

        set_lvl(0, 2); set_lvl(1, 5); set_lvl(2, 5);
        set_lvl(3, 7); set_lvl(4, 0); set_lvl(5, 3);

        // Arbitration table
        for (int k = 0; k < NV; k++) begin
            irq_req = VTAB[k][41:26]; irq_en = VTAB[k][25:10]; gmask = VTAB[k][9];
            step();
            check($sformatf("R3 table %0d int_req", k), 32'(int_req), 32'(VTAB[k][8]));
            check($sformatf("R4 table %0d vector", k), 32'(vec_addr), {16'h0, 8'hFF, VTAB[k][7:0]});
        end
        irq_req = '0; irq_en = '1; gmask = 0; step();

        // Nesting and deferred service (R6, R7, R9, R2)
        irq_req = 16'h0020; step();
        check("R6 offer src5", 32'(vec_addr), 32'hFFF4);
        ack();
        check("R5 low after ack", 32'(int_req), 0);
        check("R6 level 3", 32'(cur_lvl), 3);
        irq_req = 16'h0023; step(); step();
        check("R2 higher preempts", 32'(vec_addr), 32'hFFFC);
        ack(); step();
        check("R6 level 5", 32'(cur_lvl), 5);
        check("R9 lower held", 32'(int_req), 0);
        irq_req = 16'h0021; rti(); step();
        check("R7 restore 3", 32'(cur_lvl), 3);
        check("R2 equal level held", 32'(int_req), 0);
        irq_req = 16'h0001; rti(); step();
        check("R7 restore 0", 32'(cur_lvl), 0);
        check("R9 pending served", 32'(vec_addr), 32'hFFFE);
        ack();
        check("R6 level 2", 32'(cur_lvl), 2);
        irq_req = '0; rti();
        check("R7 back to 0", 32'(cur_lvl), 0);
        check("R10 no error", 32'(stk_err), 0);

        // Acknowledge and return in the same cycle (R11)
        irq_req = 16'h0020; step(); ack();
        irq_req = 16'h0002; step(); step();
        int_ack = 1; int_rti = 1; step(); int_ack = 0; int_rti = 0;
        check("R11 new level", 32'(cur_lvl), 5);
        irq_req = '0; rti();
        check("R11 stack intact", 32'(cur_lvl), 0);
        check("R11 no error", 32'(stk_err), 0);

        // Spurious vector (R8)
        irq_req = 16'h0001; step();
        check("R8 offered", 32'(int_req), 1);
        irq_req = '0; #1;
        check("R8 spurious vector", 32'(vec_addr), 32'hFFDE);
        ack();
        check("R8 level kept", 32'(cur_lvl), 0);
        rti();
        check("R8 balanced", 32'(stk_err), 0);

        // Base register (R4)
        base_we = 1; base_din = 8'h80; step(); base_we = 0;
        irq_req = 16'h0001; step();
        check("R4 new base", 32'(vec_addr), 32'h80FE);

        // Level write timing (R12, R1)
        set_lvl(0, 0);
        check("R12 old level still used", 32'(int_req), 1);
        step();
        check("R1 level 0 drops request", 32'(int_req), 0);
        irq_req = '0; step();

        // Underflow (R10)
        do_reset();
        rti();
        check("R10 underflow", 32'(stk_err), 1);

        // Overflow via spurious pushes (R10)
        do_reset();
        for (int k = 0; k < 9; k++) begin
            irq_req = 16'h8000; step();
            irq_req = '0; ack();
            if (k == 7) check("R10 eight pushes ok", 32'(stk_err), 0);
        end
        check("R10 overflow", 32'(stk_err), 1);
        check("R8 level after spurious", 32'(cur_lvl), 0);

        finish_run();
    end
endmodule